// File: doc/BRIEF.md
# ADC Result Readout and Channel Sorter

This block connects an on-chip monitoring converter, which steps through a fixed set of channels without pause, to the user logic that consumes its results. The converter signals every finished conversion with a one-cycle pulse and reports the channel it has just converted. The block turns that pulse straight into a read on the converter's register port. The read address is the reported channel number, widened with zeros.

When the port answers with its data-ready strobe, the block keeps the top 12 bits of the 16-bit result word. It files them into the holding register of the channel that was captured when the read was issued. Because the port's raw data bus carries a different channel on every read, consumers use only the per-channel registers. Each register has a valid bit and a one-cycle update strobe.

Eight channels are sorted: die temperature, three supply monitors, the dedicated differential input and the first three auxiliary differential inputs. Results for any other channel are discarded. Only one read may be in flight at a time. A conversion pulse that arrives while a read is pending is refused and recorded in a sticky overrun flag. A read that gets no answer within the time limit is abandoned and recorded in a sticky timeout flag.

Top module: `adc_result_sorter`

## Requirements
- R1: `rd_en_o` is high in a cycle exactly when `conv_done_i` is high and either no read is pending or the pending read completes in that same cycle. Each such cycle starts one read.
- R2: `rd_addr_o` equals `{2'b00, conv_chan_i}`: the 5-bit channel number in bits 4:0 and zeros in bits 6:5.
- R3: When a read completes, the holding register of the captured channel loads `rd_data_i[15:4]`. In the cycle after the one in which `rd_ready_i` was sampled, that slot's `slot_update_o` bit is high for one cycle and its value is visible.
- R4: Channel numbers map to slots as follows: 0x00→0 (temperature), 0x01→1, 0x02→2, 0x06→3 (supply monitors), 0x03→4 (dedicated input), 0x10→5, 0x11→6, 0x12→7 (auxiliary inputs 0..2). Slot k occupies `slot_value_o[12k+11:12k]` and bit k of the valid and update buses. At most one update bit is high at a time.
- R5: A completed read for a channel outside the map changes no slot value, no valid bit and raises no update bit.
- R6: The channel number is captured at the cycle the read is issued. Changes on `conv_chan_i` during the wait do not change where the data goes.
- R7: A `conv_done_i` pulse that arrives while a read is pending, and is not in the cycle that read completes, issues no read and sets `overrun_o`. `overrun_o` stays high until reset.
- R8: Synchronous active-high reset clears all valid bits. A slot's valid bit goes high with its first write and stays high.
- R9: A `rd_ready_i` arriving 1 to 32 cycles after the issue cycle completes the read. If none has arrived by the 32nd cycle, the read is dropped at that edge and `timeout_o` goes high and stays high until reset. A later `rd_ready_i` is ignored.
- R10: `rd_ready_i` while no read is pending has no effect on any output.
- R11: When `conv_done_i` and the completing `rd_ready_i` fall in the same cycle, the data is stored, a new read is issued and `overrun_o` stays low.
- R12: After reset, the valid bits, the update bits, `overrun_o` and `timeout_o` are all low and all slot values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter's register port |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 1 | End-of-conversion pulse from the converter |
| conv_chan_i | input | 5 | Channel number reported by the converter |
| rd_en_o | output | 1 | Read enable to the register port |
| rd_addr_o | output | 7 | Read address to the register port |
| rd_ready_i | input | 1 | Data-ready strobe from the register port |
| rd_data_i | input | 16 | Result word from the register port |
| slot_value_o | output | 96 | Eight 12-bit channel results, slot k at bits 12k+11:12k |
| slot_valid_o | output | 8 | Per-slot valid bits |
| slot_update_o | output | 8 | Per-slot one-cycle update strobes |
| overrun_o | output | 1 | Sticky flag: conversion pulse refused while busy |
| timeout_o | output | 1 | Sticky flag: read abandoned for lack of data-ready |

## Verification
Two functions can fall in the same cycle: completing a pending read on data-ready and accepting a fresh end-of-conversion pulse. The bench provokes this by raising both strobes together, with different channels on the two reads. It judges the outcome from four observations: the read enable is high in that cycle, the first channel's slot updates, the second read then lands in its own slot, and the overrun flag stays low. A separate test raises the conversion pulse in the middle of a wait and expects the opposite: no read enable and the overrun flag set.

// File: rtl/adc_sorter_pkg.sv
package adc_sorter_pkg;

   // Largest number of slots the fixed channel map provides
   localparam int unsigned MAP_SLOTS = 8;

   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_WAIT = 1'b1
   } rd_state_e;

   // Channel number that feeds each holding slot
   function automatic int unsigned slot_chan_id(input int unsigned idx);
      case (idx)
         0:       return 'h00; // die temperature
         1:       return 'h01; // supply monitor
         2:       return 'h02; // supply monitor
         3:       return 'h06; // supply monitor
         4:       return 'h03; // dedicated differential input
         5:       return 'h10; // auxiliary input 0
         6:       return 'h11; // auxiliary input 1
         default: return 'h12; // auxiliary input 2
      endcase
   endfunction

endpackage

// File: rtl/adc_rd_sequencer.sv
module adc_rd_sequencer
   import adc_sorter_pkg::*;
#(
   parameter int unsigned CHAN_W      = 5,
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned TIMEOUT_CYC = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              conv_done_i,
   input  logic [CHAN_W-1:0] conv_chan_i,
   input  logic              rd_ready_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              done_o,
   output logic [CHAN_W-1:0] done_chan_o,
   output logic              overrun_o,
   output logic              timeout_o
);

   localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

   initial begin
      assert (ADDR_W >= CHAN_W) else $error("address narrower than channel id");
      assert (TIMEOUT_CYC >= 2) else $error("timeout window too short");
   end

   rd_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CHAN_W-1:0] chan_q;
   logic              ovr_q;
   logic              tmo_q;

   logic busy;
   logic issue;
   logic expire;

   assign busy   = (state_q == RD_WAIT);
   assign done_o = busy & rd_ready_i;
   assign issue  = conv_done_i & (~busy | rd_ready_i);
   assign expire = busy & ~rd_ready_i & (cnt_q == CNT_LAST);

   assign rd_en_o     = issue;
   assign done_chan_o = chan_q;
   assign overrun_o   = ovr_q;
   assign timeout_o   = tmo_q;

   // Address: channel id in the low bits, zero padding above
   generate
      if (ADDR_W == CHAN_W) begin : g_addr_same
         assign rd_addr_o = conv_chan_i;
      end else begin : g_addr_pad
         assign rd_addr_o = {{(ADDR_W - CHAN_W){1'b0}}, conv_chan_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RD_IDLE;
         cnt_q   <= '0;
         chan_q  <= '0;
      end else if (issue) begin
         state_q <= RD_WAIT;
         cnt_q   <= '0;
         chan_q  <= conv_chan_i;
      end else if (done_o || expire) begin
         state_q <= RD_IDLE;
         cnt_q   <= '0;
      end else if (busy) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ovr_q <= 1'b0;
         tmo_q <= 1'b0;
      end else begin
         if (conv_done_i && busy && !rd_ready_i) ovr_q <= 1'b1;
         if (expire)                             tmo_q <= 1'b1;
      end
   end

   // R1: an issued read leaves the sequencer waiting on the next cycle
   p_issue_waits_r1: assert property (@(posedge clk) disable iff (rst)
      rd_en_o |=> (state_q == RD_WAIT));

   // R7: refused pulse sets the overrun flag
   p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
      (conv_done_i && busy && !rd_ready_i) |=> overrun_o);

   p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      overrun_o |=> overrun_o);

   p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      timeout_o |=> timeout_o);

   // R9: the wait counter never passes the window
   p_wait_bound_r9: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cnt_q < CNT_W'(TIMEOUT_CYC)));

   // R6: the captured channel is frozen while waiting without a new issue
   p_chan_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      (busy && !issue) |=> $stable(done_chan_o));

endmodule

// File: rtl/adc_chan_slot.sv
module adc_chan_slot #(
   parameter int unsigned CHAN_W   = 5,
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned CHAN_ID  = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                done_i,
   input  logic [CHAN_W-1:0]   chan_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic [SAMPLE_W-1:0] value_o,
   output logic                valid_o,
   output logic                update_o
);

   localparam logic [CHAN_W-1:0] MY_CHAN = CHAN_W'(CHAN_ID);

   logic hit;
   assign hit = done_i && (chan_i == MY_CHAN);

   always_ff @(posedge clk) begin
      if (rst) begin
         value_o  <= '0;
         valid_o  <= 1'b0;
         update_o <= 1'b0;
      end else begin
         update_o <= hit;
         if (hit) begin
            value_o <= sample_i;
            valid_o <= 1'b1;
         end
      end
   end

   // R3: a write shows up with its strobe one cycle later
   p_update_after_hit_r3: assert property (@(posedge clk) disable iff (rst)
      hit |=> (update_o && value_o == $past(sample_i)));

   // R5: no write, no change
   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !hit |=> ($stable(value_o) && !update_o));

   // R8: valid is sticky and accompanies every update
   p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> valid_o);

   p_update_valid_r8: assert property (@(posedge clk) disable iff (rst)
      update_o |-> valid_o);

endmodule

// File: rtl/adc_result_sorter.sv
module adc_result_sorter
   import adc_sorter_pkg::*;
#(
   parameter int unsigned CHAN_W      = 5,
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SAMPLE_W    = 12,
   parameter int unsigned NUM_SLOTS   = 8,
   parameter int unsigned TIMEOUT_CYC = 32
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          conv_done_i,
   input  logic [CHAN_W-1:0]             conv_chan_i,
   output logic                          rd_en_o,
   output logic [ADDR_W-1:0]             rd_addr_o,
   input  logic                          rd_ready_i,
   input  logic [DATA_W-1:0]             rd_data_i,
   output logic [NUM_SLOTS*SAMPLE_W-1:0] slot_value_o,
   output logic [NUM_SLOTS-1:0]          slot_valid_o,
   output logic [NUM_SLOTS-1:0]          slot_update_o,
   output logic                          overrun_o,
   output logic                          timeout_o
);

   initial begin
      assert (NUM_SLOTS >= 1 && NUM_SLOTS <= MAP_SLOTS) else $error("slot count outside channel map");
      assert (SAMPLE_W >= 1 && SAMPLE_W <= DATA_W) else $error("sample wider than result word");
      assert (CHAN_W >= 5) else $error("channel id too narrow for map");
   end

   logic              done;
   logic [CHAN_W-1:0] done_chan;
   logic [SAMPLE_W-1:0] sample;

   // Keep the most significant bits of the result word
   assign sample = rd_data_i[DATA_W-1 -: SAMPLE_W];

   generate
      if (SAMPLE_W < DATA_W) begin : g_low_bits
         logic unused_low_bits;
         assign unused_low_bits = ^rd_data_i[DATA_W-SAMPLE_W-1:0];
      end
   endgenerate

   adc_rd_sequencer #(
      .CHAN_W      (CHAN_W),
      .ADDR_W      (ADDR_W),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .conv_done_i (conv_done_i),
      .conv_chan_i (conv_chan_i),
      .rd_ready_i  (rd_ready_i),
      .rd_en_o     (rd_en_o),
      .rd_addr_o   (rd_addr_o),
      .done_o      (done),
      .done_chan_o (done_chan),
      .overrun_o   (overrun_o),
      .timeout_o   (timeout_o)
   );

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         adc_chan_slot #(
            .CHAN_W   (CHAN_W),
            .SAMPLE_W (SAMPLE_W),
            .CHAN_ID  (slot_chan_id(g))
         ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .done_i   (done),
            .chan_i   (done_chan),
            .sample_i (sample),
            .value_o  (slot_value_o[g*SAMPLE_W +: SAMPLE_W]),
            .valid_o  (slot_valid_o[g]),
            .update_o (slot_update_o[g])
         );
      end
   endgenerate

   // R4: each completed read lands in at most one slot
   p_single_update_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(slot_update_o));

   // R3: an update strobe always follows a completed read
   p_update_needs_read_r3: assert property (@(posedge clk) disable iff (rst)
      (slot_update_o != '0) |-> $past(done));

endmodule

// File: tb/tb_adc_result_sorter.sv
`timescale 1ns/1ps
module tb_adc_result_sorter;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        conv_done_i = 1'b0;
   logic [4:0]  conv_chan_i = '0;
   logic        rd_ready_i = 1'b0;
   logic [15:0] rd_data_i = '0;
   logic        rd_en_o;
   logic [6:0]  rd_addr_o;
   logic [95:0] slot_value_o;
   logic [7:0]  slot_valid_o;
   logic [7:0]  slot_update_o;
   logic        overrun_o;
   logic        timeout_o;

   always #2.5 clk = ~clk;

   adc_result_sorter dut (
      .clk(clk), .rst(rst),
      .conv_done_i(conv_done_i), .conv_chan_i(conv_chan_i),
      .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
      .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i),
      .slot_value_o(slot_value_o), .slot_valid_o(slot_valid_o),
      .slot_update_o(slot_update_o),
      .overrun_o(overrun_o), .timeout_o(timeout_o)
   );

   int n_checks = 0;
   int n_err = 0;
   bit summary_done = 1'b0;

   logic [11:0] exp_val [8];
   logic [7:0]  exp_valid;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [95:0] act, input logic [95:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int slot_of(input logic [4:0] ch);
      case (ch)
         5'h00: return 0;
         5'h01: return 1;
         5'h02: return 2;
         5'h06: return 3;
         5'h03: return 4;
         5'h10: return 5;
         5'h11: return 6;
         5'h12: return 7;
         default: return -1;
      endcase
   endfunction

   task automatic check_slots(input string req, input logic [7:0] exp_upd);
      logic [95:0] packed_exp;
      for (int k = 0; k < 8; k++) packed_exp[k*12 +: 12] = exp_val[k];
      chk(slot_update_o === exp_upd, req, "update", 96'(slot_update_o), 96'(exp_upd));
      chk(slot_valid_o === exp_valid, req, "valid", 96'(slot_valid_o), 96'(exp_valid));
      chk(slot_value_o === packed_exp, req, "values", slot_value_o, packed_exp);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      conv_done_i = 1'b0;
      rd_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 8; k++) exp_val[k] = '0;
      exp_valid = '0;
   endtask

   task automatic expect_store(input logic [4:0] ch, input logic [15:0] d, input string req);
      int s;
      s = slot_of(ch);
      if (s >= 0) begin
         exp_val[s] = d[15:4];
         exp_valid[s] = 1'b1;
         check_slots(req, 8'(1 << s));
      end else begin
         check_slots(req, 8'h00);
      end
   endtask

   // One full read: pulse, wait lat cycles (channel input scrambled), data-ready
   task automatic read_cycle(input logic [4:0] ch, input int lat, input logic [15:0] d,
                             input string req);
      @(negedge clk);
      conv_done_i = 1'b1;
      conv_chan_i = ch;
      #1;
      chk(rd_en_o === 1'b1, "R1", "read enable on pulse", 96'(rd_en_o), 96'd1);
      chk(rd_addr_o === {2'b00, ch}, "R2", "read address", 96'(rd_addr_o), 96'({2'b00, ch}));
      for (int i = 1; i <= lat; i++) begin
         @(negedge clk);
         conv_done_i = 1'b0;
         conv_chan_i = ~ch;
      end
      rd_ready_i = 1'b1;
      rd_data_i = d;
      @(negedge clk);
      rd_ready_i = 1'b0;
      rd_data_i = '0;
      #1;
      expect_store(ch, d, req);
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk(slot_valid_o === 8'h00, "R12", "valid after reset", 96'(slot_valid_o), 96'd0);
      chk(slot_update_o === 8'h00, "R12", "update after reset", 96'(slot_update_o), 96'd0);
      chk(slot_value_o === '0, "R12", "values after reset", slot_value_o, 96'd0);
      chk({overrun_o, timeout_o} === 2'b00, "R12", "flags after reset",
          96'({overrun_o, timeout_o}), 96'd0);
      chk(rd_en_o === 1'b0, "R1", "no read without pulse", 96'(rd_en_o), 96'd0);
   endtask

   task automatic t_all_channels();
      logic [4:0] chans [8] = '{5'h00, 5'h01, 5'h02, 5'h06, 5'h03, 5'h10, 5'h11, 5'h12};
      for (int k = 0; k < 8; k++)
         read_cycle(chans[k], 1 + (k * 2), 16'hA005 + 16'(k * 16'h1357), "R4");
      read_cycle(5'h02, 4, 16'h5A5F, "R3");
      chk(slot_valid_o === 8'hFF, "R8", "all valid", 96'(slot_valid_o), 96'hFF);
   endtask

   task automatic t_unmapped();
      read_cycle(5'h05, 2, 16'hFFFF, "R5");
      read_cycle(5'h13, 1, 16'h1234, "R5");
      read_cycle(5'h1F, 3, 16'hBEEF, "R5");
   endtask

   task automatic t_chan_change();
      do_reset();
      // read_cycle drives the inverted id (0x0F, unmapped) during the wait
      read_cycle(5'h10, 6, 16'hC3A0, "R6");
      chk(slot_valid_o === 8'h20, "R8", "first write sets valid", 96'(slot_valid_o), 96'h20);
   endtask

   task automatic t_overrun();
      do_reset();
      @(negedge clk); conv_done_i = 1'b1; conv_chan_i = 5'h00;
      @(negedge clk); conv_done_i = 1'b0;
      @(negedge clk); conv_done_i = 1'b1; conv_chan_i = 5'h01; #1;
      chk(rd_en_o === 1'b0, "R7", "pulse refused while pending", 96'(rd_en_o), 96'd0);
      @(negedge clk); conv_done_i = 1'b0; #1;
      chk(overrun_o === 1'b1, "R7", "overrun set", 96'(overrun_o), 96'd1);
      rd_ready_i = 1'b1; rd_data_i = 16'h7770;
      @(negedge clk); rd_ready_i = 1'b0; #1;
      expect_store(5'h00, 16'h7770, "R7");
      read_cycle(5'h01, 2, 16'h1110, "R7");
      chk(overrun_o === 1'b1, "R7", "overrun sticky", 96'(overrun_o), 96'd1);
   endtask

   task automatic t_timeout();
      do_reset();
      read_cycle(5'h03, 32, 16'h8880, "R9");
      chk(timeout_o === 1'b0, "R9", "no timeout at 32-cycle latency", 96'(timeout_o), 96'd0);
      @(negedge clk); conv_done_i = 1'b1; conv_chan_i = 5'h06;
      for (int i = 1; i <= 32; i++) begin
         @(negedge clk);
         conv_done_i = 1'b0;
      end
      #1;
      chk(timeout_o === 1'b0, "R9", "still waiting at last cycle", 96'(timeout_o), 96'd0);
      @(negedge clk); #1;
      chk(timeout_o === 1'b1, "R9", "timeout raised", 96'(timeout_o), 96'd1);
      rd_ready_i = 1'b1; rd_data_i = 16'hDDD0;
      @(negedge clk); rd_ready_i = 1'b0; #1;
      check_slots("R9", 8'h00);
      read_cycle(5'h06, 1, 16'h4440, "R9");
      chk(timeout_o === 1'b1, "R9", "timeout sticky", 96'(timeout_o), 96'd1);
   endtask

   task automatic t_stray_ready();
      do_reset();
      read_cycle(5'h11, 2, 16'h2220, "R10");
      @(negedge clk); rd_ready_i = 1'b1; rd_data_i = 16'hFFF0;
      @(negedge clk); rd_ready_i = 1'b0; #1;
      check_slots("R10", 8'h00);
      chk({overrun_o, timeout_o} === 2'b00, "R10", "flags untouched",
          96'({overrun_o, timeout_o}), 96'd0);
   endtask

   task automatic t_coincide();
      do_reset();
      @(negedge clk); conv_done_i = 1'b1; conv_chan_i = 5'h00;
      @(negedge clk); conv_done_i = 1'b0;
      @(negedge clk);
      rd_ready_i = 1'b1; rd_data_i = 16'h9990;
      conv_done_i = 1'b1; conv_chan_i = 5'h12; #1;
      chk(rd_en_o === 1'b1, "R11", "new read with completion", 96'(rd_en_o), 96'd1);
      chk(rd_addr_o === 7'h12, "R11", "new read address", 96'(rd_addr_o), 96'h12);
      @(negedge clk); rd_ready_i = 1'b0; conv_done_i = 1'b0; #1;
      expect_store(5'h00, 16'h9990, "R11");
      @(negedge clk);
      rd_ready_i = 1'b1; rd_data_i = 16'h6660;
      @(negedge clk); rd_ready_i = 1'b0; #1;
      expect_store(5'h12, 16'h6660, "R11");
      chk(overrun_o === 1'b0, "R11", "no overrun", 96'(overrun_o), 96'd0);
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_all_channels();
      t_unmapped();
      t_chan_change();
      t_overrun();
      t_timeout();
      t_stray_ready();
      t_coincide();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule